// File: doc/BRIEF.md
# CAN Controller Register and Mode Interface

This block is the register file that sits in front of a CAN controller. It is reached through a simple synchronous bus and holds the master control and status words, the bit-timing word and the acceptance-filter configuration. The protocol engine, the mailboxes and the acceptance matching are built elsewhere and are outside this block.

The block is more than a plain set of flops. A request written into the control word is acknowledged in the status word one clock later. This is the handshake for entering and leaving initialization mode and sleep mode. The acknowledge state then decides whether software may see or change the bit-timing word. The filter registers are locked or unlocked by a filter-init flag. Each filter bank is also unlocked when that bank's own activation bit is clear.

A read is captured on the clock edge where `rd_en` is high and appears on `rdata` after that edge. A write takes effect on the edge where `wr_en` is high. All offsets are byte addresses of 32-bit words.

Top module: `can_regif`

## Requirements
- R1: After reset the register values are as follows. Control word (offset 0x00) = 0x00010002. Status word (0x04) = 0x00000C02. Transmit status (0x08) = 0x1C000000. Receive status words (0x0C, 0x10), interrupt enable (0x14), error status (0x18) and `rdata` are all 0.
- R2: Control word bit 0 is the init request and bit 1 is the sleep request; only bits 16 and 7:0 of the control word are stored, the rest read 0. Status bit 0 (init acknowledge) and status bit 1 (sleep acknowledge) take their new value on the clock edge after the edge that updated the control word. Init acknowledge is the init request. Sleep acknowledge is the sleep request with no init request present. Status bits 11:10 always read 1.
- R3: The bit-timing word (0x1C) resets to 0x01230000. It reads 0 while init acknowledge is clear. Writes to it take effect only while init acknowledge is set, and only bits in mask 0xC37F03FF are stored. Bit 30 is the loopback enable.
- R4: The filter master word (0x200) resets to 0x2A1C0E01. Only bit 0, the filter-init flag, is writable; the other bits are constant.
- R5: The filter mode (0x204), filter scale (0x20C) and FIFO assignment (0x214) words are 32-bit, reset to 0, and keep their old value when written while the filter-init flag is clear.
- R6: The activation word (0x21C) holds one bit per bank for 28 banks in bits 27:0. It is writable at any time, and bits 31:28 always read 0.
- R7: Bank b, word w (w = 0 or 1) sits at 0x240 + 8*b + 4*w and resets to 0. A write to it takes effect when the filter-init flag is set or activation bit b is clear, and is dropped otherwise.
- R8: Reads of any unmapped or misaligned offset, including 0x320 just past the last bank, return 0, and writes there change nothing.
- R9: The interrupt enable word is fully writable. A read in the same cycle as a write returns the content from before the write. `rdata` holds its value in cycles without `rd_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 10 | Byte address of the 32-bit word |
| wdata | input | 32 | Write data |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| rdata | output | 32 | Read data, registered |

## Verification
Two pairs of events can fall on the same clock edge and are tested. The first pair is the edge where an acknowledge changes and an access to the word that the acknowledge gates. The bench writes the init request and, in the very next cycle, writes the bit-timing word and reads the status word. It expects the write to be dropped and the old status to be returned. The reverse case is also covered: a bit-timing read issued just after the request is withdrawn must still see the stored content. The second pair is a read and a write to the same word on one edge. The bench expects the pre-write value on `rdata` and the new value on the next read.

// File: rtl/can_regif.sv
module can_regif #(
  parameter int NBANK  = 28,
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  input  logic              wr_en,
  input  logic              rd_en,
  output logic [31:0]       rdata
);

  localparam int NWORD = NBANK * 2;
  localparam int WI_W  = $clog2(NWORD);

  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(12'h000);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(12'h004);
  localparam logic [ADDR_W-1:0] A_TXS  = ADDR_W'(12'h008);
  localparam logic [ADDR_W-1:0] A_RF0  = ADDR_W'(12'h00C);
  localparam logic [ADDR_W-1:0] A_RF1  = ADDR_W'(12'h010);
  localparam logic [ADDR_W-1:0] A_IEN  = ADDR_W'(12'h014);
  localparam logic [ADDR_W-1:0] A_ERR  = ADDR_W'(12'h018);
  localparam logic [ADDR_W-1:0] A_BTIM = ADDR_W'(12'h01C);
  localparam logic [ADDR_W-1:0] A_FMAS = ADDR_W'(12'h200);
  localparam logic [ADDR_W-1:0] A_FMOD = ADDR_W'(12'h204);
  localparam logic [ADDR_W-1:0] A_FSCL = ADDR_W'(12'h20C);
  localparam logic [ADDR_W-1:0] A_FASN = ADDR_W'(12'h214);
  localparam logic [ADDR_W-1:0] A_FACT = ADDR_W'(12'h21C);
  localparam logic [ADDR_W-1:0] A_BANK = ADDR_W'(12'h240);
  localparam logic [ADDR_W-1:0] A_BEND = ADDR_W'(32'h240 + NWORD * 4);

  localparam logic [31:0] CTRL_RST = 32'h0001_0002;
  localparam logic [31:0] CTRL_MSK = 32'h0001_00FF;
  localparam logic [31:0] STAT_FIX = 32'h0000_0C00;
  localparam logic [31:0] TXS_RST  = 32'h1C00_0000;
  localparam logic [31:0] BT_RST   = 32'h0123_0000;
  localparam logic [31:0] BT_MSK   = 32'hC37F_03FF;
  localparam logic [31:0] FMAS_FIX = 32'h2A1C_0E00;

  logic [31:0]            ctrl_q, ien_q, bt_q, fmod_q, fscl_q, fasn_q;
  logic                   ack_init, ack_sleep, finit;
  logic [NBANK-1:0]       act_q;
  logic [NWORD-1:0][31:0] bank_all;
  logic [ADDR_W-1:0]      boff;
  logic [WI_W-1:0]        widx;
  logic                   bank_hit, hit;
  logic [31:0]            rd_mux;

  assign boff     = addr - A_BANK;
  assign widx     = boff[WI_W+1:2];
  assign bank_hit = (addr >= A_BANK) && (addr < A_BEND) && (addr[1:0] == 2'b00);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q    <= CTRL_RST;
      ack_init  <= 1'b0;
      ack_sleep <= 1'b1;
      ien_q     <= '0;
      bt_q      <= BT_RST;
      finit     <= 1'b1;
      fmod_q    <= '0;
      fscl_q    <= '0;
      fasn_q    <= '0;
      act_q     <= '0;
    end else begin
      ack_init  <= ctrl_q[0];
      ack_sleep <= ctrl_q[1] & ~ctrl_q[0];
      if (wr_en) begin
        if (addr == A_CTRL) ctrl_q <= wdata & CTRL_MSK;
        if (addr == A_IEN)  ien_q  <= wdata;
        if (addr == A_BTIM && ack_init) bt_q <= wdata & BT_MSK;
        if (addr == A_FMAS) finit  <= wdata[0];
        if (addr == A_FMOD && finit) fmod_q <= wdata;
        if (addr == A_FSCL && finit) fscl_q <= wdata;
        if (addr == A_FASN && finit) fasn_q <= wdata;
        if (addr == A_FACT) act_q  <= wdata[NBANK-1:0];
      end
    end
  end

  for (genvar w = 0; w < NWORD; w++) begin : g_word
    logic [31:0] word_q;
    logic        wsel;
    assign wsel = wr_en && bank_hit && (widx == WI_W'(w));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) word_q <= '0;
      else if (wsel && (finit || !act_q[w/2])) word_q <= wdata;
    end
    assign bank_all[w] = word_q;

    a_r7_bank_locked: assert property (@(posedge clk) disable iff (!rst_n)
      (wsel && !finit && act_q[w/2]) |=> $stable(word_q));
  end

  always_comb begin
    rd_mux = '0;
    hit    = 1'b1;
    case (addr)
      A_CTRL:              rd_mux = ctrl_q;
      A_STAT:              rd_mux = STAT_FIX | {30'b0, ack_sleep, ack_init};
      A_TXS:               rd_mux = TXS_RST;
      A_RF0, A_RF1, A_ERR: rd_mux = '0;
      A_IEN:               rd_mux = ien_q;
      A_BTIM:              rd_mux = ack_init ? bt_q : '0;
      A_FMAS:              rd_mux = FMAS_FIX | {31'b0, finit};
      A_FMOD:              rd_mux = fmod_q;
      A_FSCL:              rd_mux = fscl_q;
      A_FASN:              rd_mux = fasn_q;
      A_FACT:              rd_mux = 32'(act_q);
      default: begin
        if (bank_hit) rd_mux = bank_all[widx];
        else          hit    = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end

  a_r2_acks_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(ack_init && ack_sleep));
  a_r2_ack_after_req: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_init) |-> $past(ctrl_q[0]));
  a_r3_bt_hidden: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == A_BTIM && !ack_init) |=> (rdata == '0));
  a_r3_bt_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_BTIM && !ack_init) |=> $stable(bt_q));
  a_r5_cfg_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !finit && (addr == A_FMOD || addr == A_FSCL || addr == A_FASN))
      |=> $stable({fmod_q, fscl_q, fasn_q}));
  a_r6_act_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == A_FACT) |=> ((rdata >> NBANK) == '0));
  a_r8_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !hit) |=> (rdata == '0));
  a_r9_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));

endmodule

// File: tb/can_regif_tb.sv
`timescale 1ns/1ps
module can_regif_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [9:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [31:0] rdata;
  int n_run = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  can_regif u_dut (.clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
                   .wr_en(wr_en), .rd_en(rd_en), .rdata(rdata));

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [9:0] a, output logic [31:0] d);
    addr = a; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic rdchk(input string tag, input logic [9:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(tag, d, exp);
  endtask

  task automatic t_reset_values();
    do_reset();
    chk("R1 rdata", rdata, 32'h0);
    rdchk("R1 ctrl", 10'h000, 32'h0001_0002);
    rdchk("R1 status", 10'h004, 32'h0000_0C02);
    rdchk("R1 txstat", 10'h008, 32'h1C00_0000);
    rdchk("R1 rx0", 10'h00C, 32'h0);
    rdchk("R1 rx1", 10'h010, 32'h0);
    rdchk("R1 ien", 10'h014, 32'h0);
    rdchk("R1 err", 10'h018, 32'h0);
  endtask

  task automatic t_init_handshake();
    do_reset();
    wr(10'h000, 32'h0001_0001);
    rdchk("R2 ack not yet", 10'h004, 32'h0000_0C02);
    rdchk("R2 init ack", 10'h004, 32'h0000_0C01);
    wr(10'h000, 32'h0001_0000);
    tick();
    rdchk("R2 normal", 10'h004, 32'h0000_0C00);
    wr(10'h000, 32'h0001_0002);
    tick();
    rdchk("R2 sleep ack", 10'h004, 32'h0000_0C02);
    wr(10'h000, 32'hFFFF_FFFF);
    rdchk("R2 ctrl mask", 10'h000, 32'h0001_00FF);
    rdchk("R2 init wins", 10'h004, 32'h0000_0C01);
  endtask

  task automatic t_bittiming();
    do_reset();
    rdchk("R3 hidden", 10'h01C, 32'h0);
    wr(10'h01C, 32'hFFFF_FFFF);
    wr(10'h000, 32'h0001_0001);
    wr(10'h01C, 32'h4000_0000);
    rdchk("R3 reset content", 10'h01C, 32'h0123_0000);
    wr(10'h01C, 32'hFFFF_FFFF);
    rdchk("R3 mask", 10'h01C, 32'hC37F_03FF);
    wr(10'h01C, 32'h4123_0000);
    rdchk("R3 loopback", 10'h01C, 32'h4123_0000);
    wr(10'h000, 32'h0001_0000);
    rdchk("R3 last visible", 10'h01C, 32'h4123_0000);
    rdchk("R3 hidden again", 10'h01C, 32'h0);
  endtask

  task automatic t_filter_master();
    do_reset();
    rdchk("R4 reset", 10'h200, 32'h2A1C_0E01);
    wr(10'h200, 32'h0000_0000);
    rdchk("R4 flag clear", 10'h200, 32'h2A1C_0E00);
    wr(10'h200, 32'hFFFF_FFFF);
    rdchk("R4 fixed bits", 10'h200, 32'h2A1C_0E01);
  endtask

  task automatic t_cfg_lock();
    logic [9:0] regs [3] = '{10'h204, 10'h20C, 10'h214};
    do_reset();
    for (int i = 0; i < 3; i++) begin
      rdchk("R5 reset", regs[i], 32'h0);
      wr(regs[i], 32'hFF00_00FF);
      rdchk("R5 open", regs[i], 32'hFF00_00FF);
      wr(10'h200, 32'h2A1C_0E00);
      wr(regs[i], 32'h00FF_FF00);
      rdchk("R5 locked", regs[i], 32'hFF00_00FF);
      wr(10'h200, 32'h2A1C_0E01);
    end
  endtask

  task automatic t_act_reserved();
    do_reset();
    rdchk("R6 reset", 10'h21C, 32'h0);
    wr(10'h21C, 32'hF000_0000);
    rdchk("R6 reserved", 10'h21C, 32'h0);
    wr(10'h200, 32'h0);
    wr(10'h21C, 32'hFFFF_FFFF);
    rdchk("R6 all banks", 10'h21C, 32'h0FFF_FFFF);
  endtask

  task automatic t_bank_lock();
    do_reset();
    rdchk("R7 reset b27w0", 10'h318, 32'h0);
    wr(10'h318, 32'h1234_5678);
    rdchk("R7 b27w0", 10'h318, 32'h1234_5678);
    wr(10'h21C, 32'h0FFF_FFFF);
    wr(10'h26C, 32'hDEAD_BEEF);
    rdchk("R7 finit open", 10'h26C, 32'hDEAD_BEEF);
    rdchk("R7 neighbour", 10'h268, 32'h0);
    wr(10'h200, 32'h2A1C_0E00);
    wr(10'h26C, 32'h0000_1111);
    rdchk("R7 active locked", 10'h26C, 32'hDEAD_BEEF);
    wr(10'h21C, 32'h0FFF_FFDF);
    wr(10'h26C, 32'h0000_1111);
    rdchk("R7 inactive open", 10'h26C, 32'h0000_1111);
    wr(10'h264, 32'h0000_2222);
    rdchk("R7 bank4 locked", 10'h264, 32'h0);
  endtask

  task automatic t_unmapped();
    do_reset();
    wr(10'h320, 32'hFFFF_FFFF);
    rdchk("R8 past banks", 10'h320, 32'h0);
    wr(10'h100, 32'hFFFF_FFFF);
    rdchk("R8 gap", 10'h100, 32'h0);
    wr(10'h242, 32'hFFFF_FFFF);
    rdchk("R8 misaligned", 10'h242, 32'h0);
    rdchk("R8 bank0 intact", 10'h240, 32'h0);
    rdchk("R8 ctrl intact", 10'h000, 32'h0001_0002);
  endtask

  task automatic t_same_cycle();
    do_reset();
    wr(10'h014, 32'hA5A5_5A5A);
    addr = 10'h014; wdata = 32'h0F0F_F0F0; wr_en = 1'b1; rd_en = 1'b1;
    @(negedge clk); wr_en = 1'b0; rd_en = 1'b0;
    chk("R9 old on clash", rdata, 32'hA5A5_5A5A);
    tick();
    chk("R9 hold", rdata, 32'hA5A5_5A5A);
    rdchk("R9 new", 10'h014, 32'h0F0F_F0F0);
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    t_reset_values();
    t_init_handshake();
    t_bittiming();
    t_filter_master();
    t_cfg_lock();
    t_act_reserved();
    t_bank_lock();
    t_unmapped();
    t_same_cycle();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule